// File: doc/BRIEF.md
# Break Return Address Selector

This block runs beside an in-order instruction stream that uses delayed branches. Each instruction arrives as a one-cycle strobe. The strobe carries the instruction's address, its sequential successor, flags that mark a delayed branch or a delay-slot instruction, and the branch target of a delayed branch. The block also receives one match pulse for each of four break conditions:

- an instruction fetch to be stopped before it executes;
- an instruction fetch to be stopped after it executes;
- a data access matched on its address alone;
- a data access matched on its address and its data value.

From these inputs the block decides at which instruction boundary execution stops. It raises a one-cycle break request there and holds the return address that the exception handler is to resume from.

The return address depends on two things: the kind of condition, and whether the matching instruction is a delayed branch or a delay slot. A break that would land between a delayed branch and its slot is always moved past the slot, and the branch target is saved. A match on a data value is not taken at once. A short window of following instructions must retire first, and that window is stretched past any delayed branch it reaches.

Top module: `break_return_sel`

## Requirements
- R1: A before-execution fetch match on an instruction that is not a delay slot gives `brk_req` high in the cycle after that instruction's strobe, and `brk_addr` equal to its `instr_addr`.
- R2: A before-execution fetch match on a delay-slot instruction saves the `instr_addr` of the most recent delayed branch, which is the branch owning the slot.
- R3: An after-execution fetch match on an ordinary instruction saves that instruction's `next_addr`.
- R4: An after-execution fetch match on a delayed branch raises no request at the branch. The request comes after the following slot instruction, with the `branch_target` captured with the branch. A match of this kind on a slot instruction saves that captured target at once.
- R5: A data-address match follows the same rules as R3 and R4. It saves `next_addr` on an ordinary instruction and the captured target on a slot. On a delayed branch it is deferred past the slot and saves the target.
- R6: A data-value match on an ordinary instruction raises no request for that instruction or for the next strobed instruction. The request follows the second strobed instruction after the match, with that instruction's `next_addr`. A new data-value match while the window is still counting starts the window again.
- R7: A data-value window that reaches a delayed branch breaks after that branch's slot and saves the branch target. A data-value match on a slot saves the captured target at once, and one on a delayed branch breaks after its slot with the target.
- R8: When several conditions hit the same instruction, the before-execution fetch wins, then after-execution fetch and data-address, then the data-value cases. Any break taken cancels every pending deferred break.
- R9: `brk_req` is high for exactly one cycle for each break, and only in the cycle after a strobed instruction. `brk_addr` changes only together with `brk_req`. Cycles with `instr_valid` low change no state.
- R10: An active-low reset drives `brk_req` and `brk_addr` to zero and discards any pending deferred break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | One instruction boundary this cycle |
| instr_addr | input | AW | Address of the strobed instruction |
| next_addr | input | AW | Sequential successor address |
| is_dbranch | input | 1 | Instruction is a delayed branch |
| is_dslot | input | 1 | Instruction sits in a delay slot |
| branch_target | input | AW | Target of the delayed branch (used when `is_dbranch`) |
| m_fetch_pre | input | 1 | Fetch match, stop before execution |
| m_fetch_post | input | 1 | Fetch match, stop after execution |
| m_data_addr | input | 1 | Data access match on address only |
| m_data_val | input | 1 | Data access match on address and value |
| brk_req | output | 1 | One-cycle break request |
| brk_addr | output | AW | Saved return address, held until the next break |

## Verification
The hardest state to reach from the ports is a counting data-value window that runs into a delayed branch. The window must then be carried through both the branch and its slot, while other matches and idle cycles can cancel or override it on the way. Directed sequences place the data-value match one instruction before a delayed branch and a before-execution fetch inside a running window. They also place a reset inside a pending window. The random phase then drives a well-formed stream: every delayed branch is followed by its slot, and flow jumps to the target. Sparse random matches and idle gaps in this stream reach the overlaps between pending and new conditions in many combinations.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef struct packed {
    logic pre;
    logic post;
    logic daddr;
    logic dval;
  } brs_match_t;
endpackage

// File: rtl/brs_branch_ctx.sv
module brs_branch_ctx #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [AW-1:0] br_addr_in,
  input  logic [AW-1:0] br_tgt_in,
  output logic [AW-1:0] br_addr_q,
  output logic [AW-1:0] br_tgt_q
);
  logic [AW-1:0] addr_d, tgt_d;

  always_comb begin
    addr_d = br_addr_q;
    tgt_d  = br_tgt_q;
    if (capture) begin
      addr_d = br_addr_in;
      tgt_d  = br_tgt_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_addr_q <= '0;
      br_tgt_q  <= '0;
    end else begin
      br_addr_q <= addr_d;
      br_tgt_q  <= tgt_d;
    end
  end
endmodule

// File: rtl/brs_pending.sv
module brs_pending #(
  parameter int WIN = 2,
  localparam int CW = $clog2(WIN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic take,
  input  logic defer,
  input  logic start,
  output logic slot_pend,
  output logic win_run,
  output logic win_last
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_d;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = slot_pend;
    if (step) begin
      pend_d = 1'b0;
      if (take) begin
        cnt_d = '0;
      end else if (defer) begin
        pend_d = 1'b1;
        cnt_d  = '0;
      end else if (start) begin
        cnt_d = CW'(WIN);
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      slot_pend <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      slot_pend <= pend_d;
    end
  end

  assign win_run  = (cnt_q != '0);
  assign win_last = (cnt_q == CW'(1));
endmodule

// File: rtl/brs_arbiter.sv
module brs_arbiter
  import brs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          valid,
  input  brs_match_t    m,
  input  logic          dbr,
  input  logic          slot,
  input  logic [AW-1:0] iaddr,
  input  logic [AW-1:0] naddr,
  input  logic [AW-1:0] ctx_baddr,
  input  logic [AW-1:0] ctx_tgt,
  input  logic          slot_pend,
  input  logic          win_run,
  input  logic          win_last,
  output logic          take,
  output logic [AW-1:0] take_addr,
  output logic          defer,
  output logic          start
);
  logic [AW-1:0] after_addr;

  assign after_addr = slot ? ctx_tgt : naddr;

  always_comb begin
    take      = 1'b0;
    take_addr = '0;
    defer     = 1'b0;
    start     = 1'b0;
    if (valid) begin
      if (m.pre) begin
        take      = 1'b1;
        take_addr = slot ? ctx_baddr : iaddr;
      end else if ((m.post || m.daddr) && !dbr) begin
        take      = 1'b1;
        take_addr = after_addr;
      end else if (m.dval && slot) begin
        take      = 1'b1;
        take_addr = ctx_tgt;
      end else if (slot_pend) begin
        take      = 1'b1;
        take_addr = ctx_tgt;
      end else if (win_last && !dbr) begin
        take      = 1'b1;
        take_addr = after_addr;
      end else if (dbr && (m.post || m.daddr || m.dval || win_run)) begin
        defer = 1'b1;
      end else if (m.dval) begin
        start = 1'b1;
      end
    end
  end
endmodule

// File: rtl/break_return_sel.sv
module break_return_sel
  import brs_pkg::*;
#(
  parameter int AW  = 32,
  parameter int WIN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [AW-1:0] instr_addr,
  input  logic [AW-1:0] next_addr,
  input  logic          is_dbranch,
  input  logic          is_dslot,
  input  logic [AW-1:0] branch_target,
  input  logic          m_fetch_pre,
  input  logic          m_fetch_post,
  input  logic          m_data_addr,
  input  logic          m_data_val,
  output logic          brk_req,
  output logic [AW-1:0] brk_addr
);
  brs_match_t    match;
  logic [AW-1:0] ctx_baddr, ctx_tgt, take_addr;
  logic          take, defer, start;
  logic          slot_pend, win_run, win_last;
  logic [AW-1:0] addr_d;

  assign match = '{pre: m_fetch_pre, post: m_fetch_post,
                   daddr: m_data_addr, dval: m_data_val};

  brs_branch_ctx #(.AW(AW)) u_ctx (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (instr_valid && is_dbranch),
    .br_addr_in (instr_addr),
    .br_tgt_in  (branch_target),
    .br_addr_q  (ctx_baddr),
    .br_tgt_q   (ctx_tgt)
  );

  brs_arbiter #(.AW(AW)) u_arb (
    .valid     (instr_valid),
    .m         (match),
    .dbr       (is_dbranch),
    .slot      (is_dslot),
    .iaddr     (instr_addr),
    .naddr     (next_addr),
    .ctx_baddr (ctx_baddr),
    .ctx_tgt   (ctx_tgt),
    .slot_pend (slot_pend),
    .win_run   (win_run),
    .win_last  (win_last),
    .take      (take),
    .take_addr (take_addr),
    .defer     (defer),
    .start     (start)
  );

  brs_pending #(.WIN(WIN)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (instr_valid),
    .take      (take),
    .defer     (defer),
    .start     (start),
    .slot_pend (slot_pend),
    .win_run   (win_run),
    .win_last  (win_last)
  );

  always_comb begin
    addr_d = brk_addr;
    if (take) addr_d = take_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_req  <= 1'b0;
      brk_addr <= '0;
    end else begin
      brk_req  <= take;
      brk_addr <= addr_d;
    end
  end
endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_valid,
  input logic [AW-1:0] instr_addr,
  input logic [AW-1:0] next_addr,
  input logic          is_dbranch,
  input logic          is_dslot,
  input logic          m_fetch_pre,
  input logic          m_fetch_post,
  input logic          brk_req,
  input logic [AW-1:0] brk_addr
);
  AST_PRE_OWN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && m_fetch_pre && !is_dslot) |=> (brk_req && brk_addr == $past(instr_addr))); // R1

  AST_POST_NEXT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && m_fetch_post && !m_fetch_pre && !is_dbranch && !is_dslot)
      |=> (brk_req && brk_addr == $past(next_addr))); // R3

  AST_POST_ON_BRANCH_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && is_dbranch && m_fetch_post && !m_fetch_pre) |=> !brk_req); // R4

  AST_REQ_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> !brk_req); // R9

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_req |-> $stable(brk_addr)); // R9
endmodule

bind break_return_sel brs_checker #(.AW(AW)) u_brs_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .instr_valid  (instr_valid),
  .instr_addr   (instr_addr),
  .next_addr    (next_addr),
  .is_dbranch   (is_dbranch),
  .is_dslot     (is_dslot),
  .m_fetch_pre  (m_fetch_pre),
  .m_fetch_post (m_fetch_post),
  .brk_req      (brk_req),
  .brk_addr     (brk_addr)
);

// File: tb/test_break_return_sel.sv
module test_break_return_sel;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iv = 1'b0, db = 1'b0, sl = 1'b0;
  logic          fb = 1'b0, fa = 1'b0, da = 1'b0, dv = 1'b0;
  logic [AW-1:0] ia = '0, na = '0, tg = '0;
  logic          brk_req;
  logic [AW-1:0] brk_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench expectation state
  logic          e_req = 1'b0;
  logic [AW-1:0] e_addr = '0;
  string         e_tag = "R10";
  logic          m_pend = 1'b0;
  string         m_ptag = "R4";
  int            m_cnt = 0;
  logic [AW-1:0] m_baddr = '0, m_tgt = '0;

  always #4 clk = ~clk;

  break_return_sel #(.AW(AW), .WIN(2)) i_break_return_sel (
    .clk(clk), .rst_n(rst_n), .instr_valid(iv), .instr_addr(ia),
    .next_addr(na), .is_dbranch(db), .is_dslot(sl), .branch_target(tg),
    .m_fetch_pre(fb), .m_fetch_post(fa), .m_data_addr(da), .m_data_val(dv),
    .brk_req(brk_req), .brk_addr(brk_addr)
  );

  task automatic check();
    n_chk++;
    if (brk_req !== e_req || brk_addr !== e_addr) begin
      n_fail++;
      $display("FAIL %s: req=%0b addr=%h expected req=%0b addr=%h",
               e_tag, brk_req, brk_addr, e_req, e_addr);
    end
  endtask

  // expected outcome for the instruction presented now, from R1..R10
  task automatic model();
    logic          take = 1'b0;
    logic [AW-1:0] a = '0;
    e_req = 1'b0;
    e_tag = "R9";
    if (!iv) return;
    if (fb) begin
      take = 1'b1; a = sl ? m_baddr : ia;
      e_tag = (fa || da || dv || m_pend || m_cnt != 0) ? "R8" : (sl ? "R2" : "R1");
    end else if ((fa || da) && !db) begin
      take = 1'b1; a = sl ? m_tgt : na;
      e_tag = fa ? (sl ? "R4" : "R3") : "R5";
    end else if (dv && sl) begin
      take = 1'b1; a = m_tgt; e_tag = "R7";
    end else if (m_pend) begin
      take = 1'b1; a = m_tgt; e_tag = m_ptag;
    end else if (m_cnt == 1 && !db) begin
      take = 1'b1; a = sl ? m_tgt : na; e_tag = "R6";
    end else if (db && (fa || da || dv || m_cnt != 0)) begin
      m_pend = 1'b1; m_cnt = 0;
      m_ptag = fa ? "R4" : (da ? "R5" : "R7");
    end else if (dv) begin
      m_cnt = 2;
    end else if (m_cnt != 0) begin
      m_cnt--;
    end
    if (take) begin
      e_req = 1'b1; e_addr = a; m_pend = 1'b0; m_cnt = 0;
    end else if (m_ptag != "" && !db) begin
      m_pend = 1'b0;
    end
    if (db) begin
      m_baddr = ia; m_tgt = tg;
    end
  endtask

  task automatic step(input logic v, input logic [AW-1:0] a, input logic b,
                      input logic s, input logic [AW-1:0] t, input logic p,
                      input logic q, input logic r, input logic w);
    @(negedge clk);
    check();
    iv = v; ia = a; na = a + 2; db = b; sl = s; tg = t;
    fb = p; fa = q; da = r; dv = w;
    model();
  endtask

  task automatic ins(input logic [AW-1:0] a, input logic p, input logic q,
                     input logic r, input logic w);
    step(1'b1, a, 1'b0, 1'b0, '0, p, q, r, w);
  endtask

  task automatic brn(input logic [AW-1:0] a, input logic [AW-1:0] t,
                     input logic q, input logic r, input logic w);
    step(1'b1, a, 1'b1, 1'b0, t, 1'b0, q, r, w);
  endtask

  task automatic slt(input logic [AW-1:0] a, input logic p, input logic q,
                     input logic r, input logic w);
    step(1'b1, a, 1'b0, 1'b1, '0, p, q, r, w);
  endtask

  task automatic idle();
    step(1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    check();
    iv = 1'b0; fb = 1'b0; fa = 1'b0; da = 1'b0; dv = 1'b0; db = 1'b0; sl = 1'b0;
    rst_n = 1'b0;
    e_req = 1'b0; e_addr = '0; e_tag = "R10";
    m_pend = 1'b0; m_cnt = 0; m_baddr = '0; m_tgt = '0;
    @(negedge clk);
    check(); // R10 state under reset
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] pc;
    int unsigned   r;
    logic          after_br;
    logic [AW-1:0] tgt_hold;
    void'($urandom(32'd1357));
    repeat (2) @(negedge clk);
    do_reset();                                   // R10
    ins(32'h1000, 1, 0, 0, 0); idle();            // R1
    brn(32'h1100, 32'h2000, 0, 0, 0);
    slt(32'h1102, 1, 0, 0, 0); idle();            // R2
    ins(32'h1200, 0, 1, 0, 0); idle();            // R3
    brn(32'h1300, 32'h3000, 1, 0, 0);
    slt(32'h1302, 0, 0, 0, 0); idle();            // R4 deferred past slot
    brn(32'h1400, 32'h4000, 0, 0, 0);
    slt(32'h1402, 0, 1, 0, 0); idle();            // R4 on slot
    ins(32'h1500, 0, 0, 1, 0); idle();            // R5
    brn(32'h1600, 32'h5000, 0, 0, 0);
    slt(32'h1602, 0, 0, 1, 0); idle();            // R5 on slot
    brn(32'h1680, 32'h5800, 0, 1, 0);
    slt(32'h1682, 0, 0, 0, 0); idle();            // R5 on branch
    ins(32'h1700, 0, 0, 0, 1); idle();
    ins(32'h1702, 0, 0, 0, 0); idle(); idle();
    ins(32'h1704, 0, 0, 0, 0); idle();            // R6 late break, R9 idles
    ins(32'h1780, 0, 0, 0, 1); ins(32'h1782, 0, 0, 0, 1);
    ins(32'h1784, 0, 0, 0, 0); ins(32'h1786, 0, 0, 0, 0); idle(); // R6 restart
    ins(32'h1800, 0, 0, 0, 1);
    brn(32'h1802, 32'h6000, 0, 0, 0);
    slt(32'h1804, 0, 0, 0, 0); idle();            // R7 window meets branch
    brn(32'h1880, 32'h6800, 0, 0, 0);
    slt(32'h1882, 0, 0, 0, 1); idle();            // R7 value match on slot
    ins(32'h1900, 1, 1, 1, 1); idle();            // R8 pre-fetch wins
    ins(32'h1a00, 0, 0, 0, 1);
    ins(32'h1a02, 1, 0, 0, 0);
    ins(32'h1a04, 0, 0, 0, 0); ins(32'h1a06, 0, 0, 0, 0); idle(); // R8 cancel
    ins(32'h1b00, 0, 0, 0, 1);
    do_reset();                                   // R10 drops pending
    ins(32'h1b02, 0, 0, 0, 0); ins(32'h1b04, 0, 0, 0, 0);
    ins(32'h1b06, 0, 0, 0, 0); idle();

    pc = 32'h8000; after_br = 1'b0; tgt_hold = '0;
    for (int i = 0; i < 4000; i++) begin
      r = $urandom;
      if (r[2:0] == 3'd0) begin
        idle();
      end else if (after_br) begin
        step(1'b1, pc, 1'b0, 1'b1, '0, r[8:4] == 0, r[13:9] == 0,
             r[18:14] == 0, r[23:19] == 0);
        pc = tgt_hold; after_br = 1'b0;
      end else if (r[27:25] == 3'd0) begin
        tgt_hold = {$urandom} & 32'h0000_fffe;
        step(1'b1, pc, 1'b1, 1'b0, tgt_hold, r[8:4] == 0, r[13:9] == 0,
             r[18:14] == 0, r[23:19] == 0);
        pc = pc + 2; after_br = 1'b1;
      end else begin
        step(1'b1, pc, 1'b0, 1'b0, '0, r[8:4] == 0, r[13:9] == 0,
             r[18:14] == 0, r[22:19] == 0);
        pc = pc + 2;
      end
    end
    idle(); idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule